// File: doc/BRIEF.md
# Word Address Counter with Dual Rollover

This block holds the data word address of a small serial memory made of 32 pages of 8 bytes each. A protocol engine loads it from a received word-address byte. It pulses an advance strobe after each byte that moves through the array. A mode select chooses how the counter wraps. During a write, only the byte-within-page bits step, so a burst of writes circles inside one 8-byte page and overwrites the earliest bytes once more than eight are sent. During a read, the whole address steps and wraps from the top of the array to address zero.

The register keeps its value between transactions. After any access it holds the last address touched plus one, which is the address that a later current-address read uses. A second output reports whether the present address lies in the upper half of the array (0x80 to 0xFF) while the write-protect input is active. The protocol engine uses this output to drop writes to that region.

Top module: `wordAddrCounter`

## Requirements
- R1: After reset, the address output is 0x00.
- R2: A load pulse makes the address equal to the load value on the next cycle.
- R3: An advance in write mode (readMode = 0) adds one to bits [2:0] modulo 8 and leaves bits [7:3] unchanged. For example, 0x7F is followed by 0x78.
- R4: Eight advances in a row in write mode bring the address back to its starting value, so a ninth written byte lands on the first byte of the same page.
- R5: An advance in read mode (readMode = 1) adds one to the full 8-bit address, with 0xFF followed by 0x00 and a carry across page boundaries (0x07 is followed by 0x08).
- R6: When load and advance are asserted in the same cycle, the load value is taken and the advance is ignored.
- R7: With neither load nor advance asserted, the address keeps its value for any number of cycles.
- R8: protectedHit is 1 exactly when wpActive is 1 and the address is 0x80 or above. It follows the current address in the same cycle.
- R9: Changing readMode without an advance does not change the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load the address from loadValue |
| loadValue | input | 8 | Word address byte to load |
| advance | input | 1 | Step the address after one byte is transferred |
| readMode | input | 1 | 1 = read wrap over the whole array, 0 = write wrap inside a page |
| wpActive | input | 1 | Write protect for the upper half is active |
| addr | output | 8 | Current word address |
| protectedHit | output | 1 | Address lies in the protected region while protection is on |

## Verification
Directed runs start bursts of write advances at the last byte of a page and at mid-page starting points. They then run the burst past eight bytes. These runs separate a page-local wrap from a full carry into bits [7:3]. Read advances that start at 0x07 and 0xFE show the carry across pages and the wrap to zero. Cycles with both load and advance set, and idle cycles that toggle readMode, confirm the priority and the hold behaviour. Random sequences that mix load, advance, mode and protect against a bench model then catch wrong ordering between these operations and wrong protected-region edges around 0x7F and 0x80.

// File: rtl/wac_pkg.sv
package wac_pkg;
  // Strobes sent from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic takeLoad;
    logic stepPage;
    logic stepFull;
  } wacStrobe_t;
endpackage

// File: rtl/wacControl.sv
module wacControl
  import wac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic       advance,
  input  logic       readMode,
  output wacStrobe_t strobe
);
  // Load wins over advance; the mode picks which step kind is issued.
  always_comb begin
    strobe          = '0;
    strobe.takeLoad = load;
    strobe.stepPage = !load && advance && !readMode;
    strobe.stepFull = !load && advance &&  readMode;
  end

  // R6: never more than one strobe, and a load request always yields a load
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.takeLoad, strobe.stepPage, strobe.stepFull}));
  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (load && advance) |-> (strobe.takeLoad && !strobe.stepPage && !strobe.stepFull));
endmodule

// File: rtl/wacDatapath.sv
module wacDatapath
  import wac_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int PROT_BASE  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  wacStrobe_t        strobe,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic              wpActive,
  output logic [ADDR_W-1:0] addr,
  output logic              protectedHit
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PROT_LO = ADDR_W'(PROT_BASE);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] pageNext;
  logic [ADDR_W-1:0] fullNext;
  logic              inRegion;

  assign fullNext = addrQ + 1'b1;

  generate
    if (PAGE_W == 0) begin : g_nopage
      assign pageNext = addrQ;
    end else if (PAGE_W >= ADDR_W) begin : g_wholepage
      assign pageNext = fullNext;
    end else begin : g_page
      logic [PAGE_W-1:0] lowNext;
      assign lowNext  = addrQ[PAGE_W-1:0] + 1'b1;
      assign pageNext = {addrQ[ADDR_W-1:PAGE_W], lowNext};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addrQ <= '0;
    else if (strobe.takeLoad) addrQ <= loadValue;
    else if (strobe.stepPage) addrQ <= pageNext;
    else if (strobe.stepFull) addrQ <= fullNext;
  end

  // A power-of-two upper region reduces to a test of the high bits.
  generate
    if ((PROT_BASE > 0) && ((PROT_BASE & (PROT_BASE - 1)) == 0) &&
        (PROT_BASE == (1 << (ADDR_W - 1)))) begin : g_msb
      assign inRegion = addrQ[ADDR_W-1];
    end else begin : g_cmp
      assign inRegion = (addrQ >= PROT_LO);
    end
  endgenerate

  assign addr         = addrQ;
  assign protectedHit = wpActive && inRegion;

  // R2: a load appears on the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeLoad |=> (addrQ == $past(loadValue)));
  // R3: a page step keeps the page bits and moves the low bits by one
  p_page_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepPage |=> (addrQ[ADDR_W-1:PAGE_W] == $past(addrQ[ADDR_W-1:PAGE_W])));
  p_page_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepPage |=> (addrQ[PAGE_W-1:0] == $past(addrQ[PAGE_W-1:0]) + 1'b1));
  // R5: a full step adds one modulo the array size
  p_full_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepFull |=> (addrQ == $past(addrQ) + 1'b1));
  // R7: no strobe, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(addrQ));
  // R8: the flag is never raised while protection is off
  p_prot_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wpActive |-> !protectedHit);
endmodule

// File: rtl/wordAddrCounter.sv
module wordAddrCounter
  import wac_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int PROT_BASE  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic              advance,
  input  logic              readMode,
  input  logic              wpActive,
  output logic [ADDR_W-1:0] addr,
  output logic              protectedHit
);
  wacStrobe_t strobe;

  wacControl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .load     (load),
    .advance  (advance),
    .readMode (readMode),
    .strobe   (strobe)
  );

  wacDatapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .PROT_BASE  (PROT_BASE)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .loadValue    (loadValue),
    .wpActive     (wpActive),
    .addr         (addr),
    .protectedHit (protectedHit)
  );

  // R9: a mode change alone leaves the address alone
  p_mode_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !advance && (readMode != $past(readMode))) |=> $stable(addr));
endmodule

// File: tb/wordAddrCounter_tb_top.sv
`timescale 1ns/1ps
module wordAddrCounter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       load = 1'b0;
  logic [7:0] loadValue = 8'h00;
  logic       advance = 1'b0;
  logic       readMode = 1'b0;
  logic       wpActive = 1'b0;
  logic [7:0] addr;
  logic       protectedHit;

  int checks = 0;
  int failures = 0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  wordAddrCounter dut_i (
    .clk(clk), .rstN(rstN), .load(load), .loadValue(loadValue),
    .advance(advance), .readMode(readMode), .wpActive(wpActive),
    .addr(addr), .protectedHit(protectedHit)
  );

  function automatic logic [7:0] nextAddr(logic [7:0] cur, logic ld, logic [7:0] lv,
                                          logic adv, logic rd);
    if (ld) return lv;
    if (!adv) return cur;
    if (rd) return cur + 8'd1;
    return {cur[7:3], cur[2:0] + 3'd1};
  endfunction

  function automatic logic expProt(logic [7:0] a, logic wp);
    return wp && (a >= 8'h80);
  endfunction

  task automatic checkAddr(string tag, logic [7:0] exp);
    checks++;
    if (addr !== exp) begin
      failures++;
      $display("FAIL %s addr actual=%02h expected=%02h", tag, addr, exp);
    end
  endtask

  task automatic checkProt(string tag);
    logic e;
    e = expProt(model, wpActive);
    checks++;
    if (protectedHit !== e) begin
      failures++;
      $display("FAIL %s protectedHit actual=%0b expected=%0b (addr %02h wp %0b)",
               tag, protectedHit, e, model, wpActive);
    end
  endtask

  // Inputs change on the falling edge; the result is checked one falling edge later.
  task automatic step(logic ld, logic [7:0] lv, logic adv, logic rd, string tag);
    load = ld; loadValue = lv; advance = adv; readMode = rd;
    model = nextAddr(model, ld, lv, adv, rd);
    @(negedge clk);
    checkAddr(tag, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] start;
    repeat (3) @(negedge clk);
    checkAddr("R1 reset", 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    checkAddr("R1 after release", 8'h00);

    step(1, 8'h7D, 0, 0, "R2 load");
    step(0, 8'h00, 1, 0, "R3 write step");
    step(0, 8'h00, 1, 0, "R3 write step to 7F");
    step(0, 8'h00, 1, 0, "R3 page wrap 7F->78");
    start = 8'h7D;
    for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0, "R3 write step");
    checkAddr("R4 back to start after eight", start);
    step(1, 8'h33, 0, 0, "R2 load 33");
    for (int i = 0; i < 8; i++) step(0, 8'h00, 1, 0, "R4 eight write steps");
    checkAddr("R4 ninth byte slot", 8'h33);

    step(1, 8'h07, 0, 1, "R2 load 07");
    step(0, 8'h00, 1, 1, "R5 carry 07->08");
    step(1, 8'hFE, 0, 1, "R2 load FE");
    step(0, 8'h00, 1, 1, "R5 read step FF");
    step(0, 8'h00, 1, 1, "R5 wrap FF->00");

    step(1, 8'hA7, 1, 0, "R6 load beats write step");
    step(1, 8'h5C, 1, 1, "R6 load beats read step");

    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, i[0], "R9 mode toggle no advance");
    for (int i = 0; i < 6; i++) step(0, 8'h00, 0, 0, "R7 hold");

    wpActive = 1'b0; step(1, 8'hFF, 0, 0, "R2 load FF");
    checkProt("R8 wp off at FF");
    wpActive = 1'b1; #0.1; checkProt("R8 wp on at FF");
    step(1, 8'h80, 0, 0, "R2 load 80");
    checkProt("R8 wp on at 80");
    step(1, 8'h7F, 0, 0, "R2 load 7F");
    checkProt("R8 wp on at 7F");
    step(0, 8'h00, 1, 1, "R5 read step 7F->80");
    checkProt("R8 follows step to 80");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic ld, adv, rd;
      logic [7:0] lv;
      string tag;
      ld  = ($urandom % 6) == 0;
      adv = ($urandom % 3) != 0;
      rd  = $urandom % 2;
      lv  = $urandom % 256;
      wpActive = $urandom % 2;
      if (ld && adv) tag = "R6 random load+advance";
      else if (ld) tag = "R2 random load";
      else if (adv && rd) tag = "R5 random read step";
      else if (adv) tag = "R3 random write step";
      else tag = "R7 random hold";
      step(ld, lv, adv, rd, tag);
      checkProt("R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : seedInit
    int unsigned s;
    s = $urandom(32'h5EED_1234);
  end
endmodule